// File: doc/BRIEF.md
# Four-Channel Legacy DMA Register File

This block is the byte-wide programming front end of one four-channel legacy DMA controller. Software reaches it through a 4-bit I/O offset and an 8-bit data path. Each channel owns a 16-bit current address and a 16-bit current count. Both are loaded and read one byte at a time through a single port per register. One shared pointer flip-flop decides whether an access hits the low byte or the high byte.

Beside the per-channel registers, the block holds these:
- a command byte;
- a four-bit mask;
- a six-bit mode field per channel;
- terminal-count flags that the transfer engine sets.

A few offsets are commands rather than storage: clearing the pointer, master clear, clearing all masks and loading all masks. The per-channel state drives the transfer engine directly through flat output buses. The count is stored exactly as software writes it, which is the number of transfers minus one.

Top module: `ldma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, the pointer selects the low byte, and address, count, mode, command and terminal-count flags are all zero.
- R2: A write to offset 2n loads one byte of the address of channel n, and a write to offset 2n+1 loads one byte of its count. The pointer picks the byte: 0 selects bits [7:0] and 1 selects bits [15:8]. Channel n's address appears on `ch_addr[16n+15:16n]` and its count on `ch_count[16n+15:16n]`. A cycle without a write changes neither bus.
- R3: Every read or write to offsets 0x0 to 0x7 toggles the one pointer that all channels and both register kinds share.
- R4: A write of any value to offset 0xC sets the pointer to the low byte.
- R5: A write to offset 0xA selects channel `wdata[1:0]`. It sets that channel's mask bit when `wdata[2]`=1 and clears it when `wdata[2]`=0. Channel n's mask bit is `ch_mask[n]`.
- R6: A write to offset 0xB stores `wdata[7:2]` as the mode of channel `wdata[1:0]`, on `ch_mode[6n+5:6n]`. For example, 0x44 stores 0x11, 0x48 stores 0x12 and 0xC0 stores 0x30.
- R7: A write to offset 0xE clears all four mask bits. A write to offset 0xF copies `wdata[3:0]` into the mask bits.
- R8: A write to offset 0xD performs a master clear. The pointer goes to the low byte, all mask bits are set, and the command byte and terminal-count flags are cleared. Addresses, counts and modes keep their values.
- R9: A read of offset 2n or 2n+1 returns the byte of that register that the pointer selects.
- R10: A write to offset 0x8 stores the command byte on `cmd_out`. A read of offset 0x8 returns status: bit n is the terminal-count flag of channel n, and bit 4+n is the live `dreq_in[n]`. The read clears the flags, but a `tc_in` pulse in the same cycle leaves its flag set.
- R11: Reads of offsets 0x9 to 0xF return 0x00. A write to offset 0x9 changes no mask bit and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | I/O offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, ignored when io_wr is high |
| io_rdata | output | 8 | Read data, combinational |
| tc_in | input | 4 | Terminal-count pulses from the engine |
| dreq_in | input | 4 | Live request lines for status |
| ch_mask | output | 4 | Mask bit per channel |
| ch_mode | output | 24 | Six-bit mode per channel |
| ch_addr | output | 64 | Current address per channel |
| ch_count | output | 64 | Current count per channel |
| cmd_out | output | 8 | Command byte |

## Verification
A status read that clears the terminal-count flags can land in the same cycle as a new terminal-count pulse from the engine. The bench raises `tc_in` on a channel during the same clock as a read of offset 0x8. It expects that read to return the old flags, and the following read to show the new flag still set. A second overlap is a pointer clear that arrives midway through a two-byte load. The bench expects the next byte written to land in the low half again.

// File: rtl/ldma_regfile.sv
module ldma_regfile #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       io_addr,
  input  logic [7:0]       io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic [7:0]       io_rdata,
  input  logic [NCH-1:0]   tc_in,
  input  logic [NCH-1:0]   dreq_in,
  output logic [NCH-1:0]   ch_mask,
  output logic [6*NCH-1:0] ch_mode,
  output logic [16*NCH-1:0] ch_addr,
  output logic [16*NCH-1:0] ch_count,
  output logic [7:0]       cmd_out
);
  localparam logic [3:0] OFS_CMD  = 4'h8;
  localparam logic [3:0] OFS_MSK1 = 4'hA;
  localparam logic [3:0] OFS_MODE = 4'hB;
  localparam logic [3:0] OFS_PTR  = 4'hC;
  localparam logic [3:0] OFS_MCLR = 4'hD;
  localparam logic [3:0] OFS_MCLA = 4'hE;
  localparam logic [3:0] OFS_MALL = 4'hF;

  logic [15:0]    addr_q [NCH];
  logic [15:0]    cnt_q  [NCH];
  logic [5:0]     mode_q [NCH];
  logic [NCH-1:0] mask_q, tc_q;
  logic [7:0]     cmd_q;
  logic           ff_q;

  wire       rd      = io_rd & ~io_wr;
  wire       ch_port = ~io_addr[3];
  wire [1:0] sel     = io_addr[2:1];
  wire       ch_acc  = ch_port & (io_wr | rd);
  wire       mclr    = io_wr & (io_addr == OFS_MCLR);
  wire       clr_ptr = (io_wr & (io_addr == OFS_PTR)) | mclr;
  wire       st_rd   = rd & (io_addr == OFS_CMD);
  wire [15:0] rsel   = io_addr[0] ? cnt_q[sel] : addr_q[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        mode_q[i] <= '0;
      end
      mask_q <= '1;
      tc_q   <= '0;
      cmd_q  <= '0;
      ff_q   <= 1'b0;
    end else begin
      if (clr_ptr)     ff_q <= 1'b0;
      else if (ch_acc) ff_q <= ~ff_q;

      if (io_wr && ch_port) begin
        if (io_addr[0]) begin
          if (ff_q) cnt_q[sel][15:8] <= io_wdata;
          else      cnt_q[sel][7:0]  <= io_wdata;
        end else begin
          if (ff_q) addr_q[sel][15:8] <= io_wdata;
          else      addr_q[sel][7:0]  <= io_wdata;
        end
      end

      if (io_wr) begin
        case (io_addr)
          OFS_CMD:  cmd_q <= io_wdata;
          OFS_MSK1: mask_q[io_wdata[1:0]] <= io_wdata[2];
          OFS_MODE: mode_q[io_wdata[1:0]] <= io_wdata[7:2];
          OFS_MCLR: begin mask_q <= '1; cmd_q <= '0; end
          OFS_MCLA: mask_q <= '0;
          OFS_MALL: mask_q <= io_wdata[NCH-1:0];
          default: ;
        endcase
      end

      tc_q <= mclr ? '0 : ((st_rd ? '0 : tc_q) | tc_in);
    end
  end

  always_comb begin
    if (ch_port)                 io_rdata = ff_q ? rsel[15:8] : rsel[7:0];
    else if (io_addr == OFS_CMD) io_rdata = {dreq_in, tc_q};
    else                         io_rdata = 8'h00;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_addr[16*g +: 16] = addr_q[g];
    assign ch_count[16*g +: 16] = cnt_q[g];
    assign ch_mode[6*g +: 6]   = mode_q[g];
  end

  assign ch_mask = mask_q;
  assign cmd_out = cmd_q;
endmodule

// File: rtl/ldma_regfile_chk.sv
module ldma_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  io_addr,
  input logic [7:0]  io_wdata,
  input logic        io_wr,
  input logic        io_rd,
  input logic [3:0]  ch_mask,
  input logic [63:0] ch_addr,
  input logic [63:0] ch_count,
  input logic [7:0]  cmd_out,
  input logic        ff_q
);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(ch_addr) && $stable(ch_count)));

  p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_wr || io_rd) && !io_addr[3]) |=> (ff_q != $past(ff_q)));

  p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hC) |=> !ff_q);

  p_single_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hA) |=> (ch_mask[$past(io_wdata[1:0])] == $past(io_wdata[2])));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hE) |=> (ch_mask == 4'h0));

  p_master_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hD) |=> (ch_mask == 4'hF && cmd_out == 8'h00 && !ff_q));
endmodule

bind ldma_regfile ldma_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .ch_mask(ch_mask), .ch_addr(ch_addr),
  .ch_count(ch_count), .cmd_out(cmd_out), .ff_q(ff_q)
);

// File: tb/ldma_regfile_tb.sv
module ldma_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [3:0]  tc_in = '0, dreq_in = '0;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] ch_addr, ch_count;
  logic [7:0]  cmd_out;
  int total = 0, bad = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  ldma_regfile u_dut (.*);

  // {wr, rd, offset, wdata, expected read, requirement number}
  localparam logic [25:0] VEC [0:16] = '{
    {1'b1, 1'b0, 4'hC, 8'h00, 8'h00, 4'd4},  // R4 pointer to low
    {1'b1, 1'b0, 4'h2, 8'h34, 8'h00, 4'd2},  // R2 ch1 address low
    {1'b1, 1'b0, 4'h2, 8'h12, 8'h00, 4'd2},  // R2 ch1 address high
    {1'b0, 1'b1, 4'h2, 8'h00, 8'h34, 4'd9},  // R9 low byte
    {1'b0, 1'b1, 4'h2, 8'h00, 8'h12, 4'd9},  // R9 high byte
    {1'b1, 1'b0, 4'h7, 8'hFF, 8'h00, 4'd2},  // ch3 count low
    {1'b1, 1'b0, 4'hC, 8'h00, 8'h00, 4'd4},  // R4 clear mid-load
    {1'b1, 1'b0, 4'h7, 8'hAB, 8'h00, 4'd4},  // low again
    {1'b1, 1'b0, 4'h7, 8'hCD, 8'h00, 4'd2},  // high
    {1'b0, 1'b1, 4'h7, 8'h00, 8'hAB, 4'd9},  // R9 count low
    {1'b0, 1'b1, 4'h0, 8'h00, 8'h00, 4'd3},  // R3 shared pointer: ch0 high
    {1'b0, 1'b1, 4'h2, 8'h00, 8'h34, 4'd3},  // R3 ch1 low after wrap
    {1'b1, 1'b0, 4'h3, 8'h00, 8'h00, 4'd3},  // R3 toggles: ch1 count high
    {1'b1, 1'b0, 4'h1, 8'h11, 8'h00, 4'd3},  // ch0 count low
    {1'b1, 1'b0, 4'h3, 8'h22, 8'h00, 4'd3},  // ch1 count high
    {1'b0, 1'b1, 4'h3, 8'h00, 8'h00, 4'd9},  // ch1 count low
    {1'b0, 1'b1, 4'h3, 8'h00, 8'h22, 4'd9}   // ch1 count high
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    #1 got = io_rdata;
    @(posedge clk);
    #1 io_wr = 1'b0; io_rd = 1'b0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(ch_mask == 4'hF, "R1", 64'(ch_mask), 64'hF);
    chk(ch_addr == 0 && ch_count == 0, "R1", ch_addr | ch_count, 0);
    chk(ch_mode == 0 && cmd_out == 0, "R1", 64'({ch_mode, cmd_out}), 0);
    op(0, 1, 4'h8, 0);
    chk(got == 8'h00, "R1", 64'(got), 0);

    for (int i = 0; i < 17; i++) begin
      op(VEC[i][25], VEC[i][24], VEC[i][23:20], VEC[i][19:12]);
      if (VEC[i][24]) begin
        total++;
        if (got != VEC[i][11:4]) begin
          bad++;
          $display("FAIL R%0d row %0d actual=%0h expected=%0h", VEC[i][3:0], i, got, VEC[i][11:4]);
        end
      end
    end
    // R2 output buses
    chk(ch_addr[31:16] == 16'h1234, "R2", 64'(ch_addr[31:16]), 64'h1234);
    chk(ch_count[63:48] == 16'hCDAB, "R2", 64'(ch_count[63:48]), 64'hCDAB);
    chk(ch_count[15:0] == 16'h0011, "R2", 64'(ch_count[15:0]), 64'h11);
    chk(ch_count[31:16] == 16'h2200, "R2", 64'(ch_count[31:16]), 64'h2200);

    // R5 single mask
    op(1, 0, 4'hA, 8'h01);
    chk(ch_mask == 4'b1101, "R5", 64'(ch_mask), 64'hD);
    op(1, 0, 4'hA, 8'h06);
    chk(ch_mask == 4'b1101, "R5", 64'(ch_mask), 64'hD);
    op(1, 0, 4'hA, 8'h02);
    chk(ch_mask == 4'b1001, "R5", 64'(ch_mask), 64'h9);

    // R6 modes
    op(1, 0, 4'hB, 8'h46);
    chk(ch_mode[17:12] == 6'h11, "R6", 64'(ch_mode[17:12]), 64'h11);
    op(1, 0, 4'hB, 8'hC3);
    chk(ch_mode[23:18] == 6'h30, "R6", 64'(ch_mode[23:18]), 64'h30);
    op(1, 0, 4'hB, 8'h48);
    chk(ch_mode[5:0] == 6'h12 && ch_mode[11:6] == 0, "R6", 64'(ch_mode), 64'hC11012);

    // R7 group mask
    op(1, 0, 4'hE, 8'hFF);
    chk(ch_mask == 4'h0, "R7", 64'(ch_mask), 0);
    op(1, 0, 4'hF, 8'hF5);
    chk(ch_mask == 4'h5, "R7", 64'(ch_mask), 5);

    // R10 command and status
    op(1, 0, 4'h8, 8'h5A);
    chk(cmd_out == 8'h5A, "R10", 64'(cmd_out), 64'h5A);
    dreq_in = 4'b1000;
    @(negedge clk); tc_in = 4'b0010;
    @(negedge clk); tc_in = 4'b0000;
    op(0, 1, 4'h8, 0);
    chk(got == 8'h82, "R10", 64'(got), 64'h82);
    op(0, 1, 4'h8, 0);
    chk(got == 8'h80, "R10", 64'(got), 64'h80);
    @(negedge clk);
    io_rd = 1'b1; io_addr = 4'h8; tc_in = 4'b0001;
    #1 got = io_rdata;
    @(posedge clk);
    #1 io_rd = 1'b0; tc_in = 4'b0000;
    chk(got == 8'h80, "R10", 64'(got), 64'h80);
    op(0, 1, 4'h8, 0);
    chk(got == 8'h81, "R10 same-cycle", 64'(got), 64'h81);

    // R8 master clear
    @(negedge clk); tc_in = 4'b0100;
    @(negedge clk); tc_in = 4'b0000;
    op(1, 0, 4'h0, 8'h77);
    op(1, 0, 4'hD, 8'h00);
    chk(ch_mask == 4'hF && cmd_out == 8'h00, "R8", 64'({ch_mask, cmd_out}), 64'hF00);
    chk(ch_addr[15:0] == 16'h0077 && ch_mode[5:0] == 6'h12, "R8", 64'(ch_addr[15:0]), 64'h77);
    op(0, 1, 4'h2, 0);
    chk(got == 8'h34, "R8", 64'(got), 64'h34);
    op(0, 1, 4'h8, 0);
    chk(got == 8'h80, "R8", 64'(got), 64'h80);

    // R11 non-data offsets; pointer now high
    op(0, 1, 4'hD, 0);
    chk(got == 8'h00, "R11", 64'(got), 0);
    op(1, 0, 4'h9, 8'hFF);
    chk(ch_mask == 4'hF, "R11", 64'(ch_mask), 64'hF);
    op(0, 1, 4'h9, 0);
    chk(got == 8'h00, "R11", 64'(got), 0);
    op(0, 1, 4'h2, 0);
    chk(got == 8'h12, "R11", 64'(got), 64'h12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule